// File: doc/BRIEF.md
# Single-Channel Legacy Bus DMA Controller

This block moves bytes between one peripheral and memory on an 8-bit legacy system bus. The peripheral asks for service with a request line. The channel then asks the processor for the bus with a hold request and waits for the hold grant. It answers the peripheral with an acknowledge and drives a 16-bit memory address. In each transfer it asserts a memory strobe and the opposite I/O strobe at the same time, so the data byte passes straight from the peripheral to memory or from memory to the peripheral. No I/O port address is ever put on the bus.

Software loads a base address, a base count and a mode word, then unmasks the channel. Unmasking copies the base values into the working address and count. The channel has four service modes:

- **Single:** releases the bus after every byte.
- **Demand:** keeps the bus while the request stays high.
- **Block:** runs to the end of the count whatever the request line does.
- **Cascade:** only relays request and grant for an external bus master and drives nothing.

A compressed-timing option shortens each transfer to two clocks. A transfer costs three clocks when the upper address byte has to be set up again.

When the count runs out, the channel flags terminal count during the last transfer. It then sets a status flag and masks itself.

Top module: `dma_chan`

## Requirements
- R1: After reset the channel is masked, the terminal-count flag is clear, and hold request and acknowledge are low. The address and command enables are also low.
- R2: A write with select 0 loads the base address, select 1 loads the base count, and select 2 loads the mode word. The mode word holds: bits [1:0] service mode (00 demand, 01 single, 10 block, 11 cascade), bit 2 direction (1 = memory to device), and bit 3 compressed timing. Select 3 writes the mask from bit 0. Writing 0 there copies base address and count into the working registers and clears the terminal-count flag, so a finished job can be rerun from the same base.
- R3: While masked, a high request line is ignored: hold request and acknowledge stay low.
- R4: On a request the channel raises hold request. It asserts acknowledge and drives the address and command lines only after the hold grant arrives.
- R5: Each transfer has exactly one strobe pulse. Device-to-memory uses I/O read with memory write. Memory-to-device uses memory read with I/O write. The other pair stays inactive. The address driven is the working address, which rises by one per transfer and wraps within 16 bits.
- R6: With normal timing every transfer holds acknowledge for exactly 4 clocks.
- R7: With compressed timing a transfer holds acknowledge for 2 clocks. It takes 3 clocks for the first transfer after the bus is won, and when the previous address had its low byte at 0xFF.
- R8: A count value C yields C+1 transfers. The terminal-count output is high during the last transfer only. Afterwards the terminal-count flag and the mask are both set.
- R9: In single mode the hold request drops after every transfer, so an N-byte job raises it N times.
- R10: In block mode transfers continue under one hold request until terminal count, even if the request line falls.
- R11: In demand mode a low request at the end of a transfer ends the burst and releases the bus. A later request resumes at the next address.
- R12: In cascade mode hold request follows the request line and acknowledge follows the hold grant. The address and command enables stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target select |
| cfg_wdata_i | input | 16 | Configuration write data |
| dreq_i | input | 1 | Peripheral service request |
| hlda_i | input | 1 | Processor hold grant |
| hrq_o | output | 1 | Hold request to the processor |
| dack_o | output | 1 | Acknowledge to the peripheral |
| addr_o | output | 16 | Memory address |
| addr_oe_o | output | 1 | Address drive enable |
| cmd_oe_o | output | 1 | Command strobe drive enable |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memw_n_o | output | 1 | Memory write strobe, active low |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |
| tc_o | output | 1 | Terminal count, high during the last transfer |
| tc_flag_o | output | 1 | Terminal count reached status |
| masked_o | output | 1 | Channel mask status |

## Verification
The assertions take two things for granted. First, the processor keeps the hold grant high for as long as hold request stays high. Second, configuration writes arrive only while the channel is idle. The stimulus respects both. The grant is a one-cycle-late copy of hold request, and grant withholding starts only before a job begins. All configuration writes happen after a job has ended or before the request line is raised. The request line changes only at falling clock edges.

// File: rtl/dma_chan_pkg.sv
// Shared types for the DMA channel: service mode codes, configuration
// select codes and transfer sequencer states.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        XM_DEMAND  = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_BLOCK   = 2'b10,
        XM_CASCADE = 2'b11
    } xfer_mode_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_MODE = 2'd2;
    localparam logic [1:0] SEL_MASK = 2'd3;

    // S_ADR sets up the upper address byte, S_STB/S_EXT carry the strobe,
    // S_END closes the transfer and advances the counters.
    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_ADR, S_STB, S_EXT, S_END
    } seq_state_e;

endpackage

// File: rtl/dma_chan_regs.sv
// Configuration and working registers of the channel.
// Holds base and working address/count, the mode word, the mask and the
// terminal-count flag. Assumes configuration writes occur only while idle.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [AW-1:0] cfg_wdata_i,
    input  logic          step_i,
    output logic [AW-1:0] cur_addr_o,
    output logic          last_o,
    output logic          low_full_o,
    output xfer_mode_e    mode_o,
    output logic          to_dev_o,
    output logic          compressed_o,
    output logic          masked_o,
    output logic          tc_flag_o
);

    logic [AW-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
    xfer_mode_e    mode_q;
    logic          to_dev_q, comp_q, masked_q, tc_q;

    // Register writes, unmask reload and per-transfer counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
            cur_addr_q  <= '0;
            cur_cnt_q   <= '0;
            mode_q      <= XM_DEMAND;
            to_dev_q    <= 1'b0;
            comp_q      <= 1'b0;
            masked_q    <= 1'b1;
            tc_q        <= 1'b0;
        end else if (cfg_we_i) begin
            case (cfg_sel_i)
                SEL_ADDR: base_addr_q <= cfg_wdata_i;
                SEL_CNT:  base_cnt_q  <= cfg_wdata_i;
                SEL_MODE: begin
                    mode_q   <= xfer_mode_e'(cfg_wdata_i[1:0]);
                    to_dev_q <= cfg_wdata_i[2];
                    comp_q   <= cfg_wdata_i[3];
                end
                default: begin
                    masked_q <= cfg_wdata_i[0];
                    if (!cfg_wdata_i[0]) begin
                        cur_addr_q <= base_addr_q;
                        cur_cnt_q  <= base_cnt_q;
                        tc_q       <= 1'b0;
                    end
                end
            endcase
        end else if (step_i) begin
            cur_addr_q <= cur_addr_q + AW'(1);
            cur_cnt_q  <= cur_cnt_q - AW'(1);
            if (cur_cnt_q == '0) begin
                tc_q     <= 1'b1;
                masked_q <= 1'b1;
            end
        end
    end

    // Status and decode outputs for the sequencer and the bus.
    always_comb begin
        cur_addr_o   = cur_addr_q;
        last_o       = (cur_cnt_q == '0);
        low_full_o   = &cur_addr_q[LW-1:0];
        mode_o       = mode_q;
        to_dev_o     = to_dev_q;
        compressed_o = comp_q;
        masked_o     = masked_q;
        tc_flag_o    = tc_q;
    end

endmodule

// File: rtl/dma_chan_seq.sv
// Transfer sequencer: hold handshake, per-byte phase timing, service-mode
// continuation and cascade pass-through. Assumes the processor keeps the
// grant high while hold request is high.
module dma_chan_seq
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dreq_i,
    input  logic       hlda_i,
    input  logic       masked_i,
    input  xfer_mode_e mode_i,
    input  logic       compressed_i,
    input  logic       last_i,
    input  logic       low_full_i,
    output logic       hrq_o,
    output logic       dack_o,
    output logic       drive_o,
    output logic       strobe_o,
    output logic       step_o
);

    seq_state_e state_q, state_d;
    logic       cascade, busy, more;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Continuation rule at the end of a transfer, by service mode.
    always_comb begin
        cascade = (mode_i == XM_CASCADE);
        more    = !last_i && ((mode_i == XM_BLOCK) ||
                              ((mode_i == XM_DEMAND) && dreq_i));
    end

    // Next-state logic for the hold handshake and the transfer phases.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: if (!masked_i && dreq_i && !cascade) state_d = S_REQ;
            S_REQ:  if (hlda_i) state_d = S_ADR;
            S_ADR:  state_d = S_STB;
            S_STB:  state_d = compressed_i ? S_END : S_EXT;
            S_EXT:  state_d = S_END;
            S_END: begin
                if (!more)                         state_d = S_IDLE;
                else if (compressed_i && !low_full_i) state_d = S_STB;
                else                               state_d = S_ADR;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Bus-side outputs; cascade mode only relays request and grant.
    always_comb begin
        busy     = (state_q == S_ADR) || (state_q == S_STB) ||
                   (state_q == S_EXT) || (state_q == S_END);
        hrq_o    = cascade ? (dreq_i && !masked_i) : (state_q != S_IDLE);
        dack_o   = cascade ? (dreq_i && hlda_i && !masked_i) : busy;
        drive_o  = !cascade && busy;
        strobe_o = !cascade && ((state_q == S_STB) || (state_q == S_EXT));
        step_o   = !cascade && (state_q == S_END);
    end

endmodule

// File: rtl/dma_chan.sv
// Single-channel DMA controller top: joins the register file and the
// sequencer and forms the paired memory/I/O strobes. Assumes one channel,
// incrementing addresses and no port address on the bus.
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [AW-1:0] cfg_wdata_i,
    input  logic          dreq_i,
    input  logic          hlda_i,
    output logic          hrq_o,
    output logic          dack_o,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe_o,
    output logic          cmd_oe_o,
    output logic          memr_n_o,
    output logic          memw_n_o,
    output logic          ior_n_o,
    output logic          iow_n_o,
    output logic          tc_o,
    output logic          tc_flag_o,
    output logic          masked_o
);

    xfer_mode_e mode;
    logic       to_dev, comp, last, low_full, masked, step;
    logic       drive, strobe, is_cascade;

    dma_chan_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .step_i(step),
        .cur_addr_o(addr_o), .last_o(last), .low_full_o(low_full),
        .mode_o(mode), .to_dev_o(to_dev), .compressed_o(comp),
        .masked_o(masked), .tc_flag_o(tc_flag_o)
    );

    dma_chan_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .dreq_i(dreq_i), .hlda_i(hlda_i),
        .masked_i(masked), .mode_i(mode), .compressed_i(comp),
        .last_i(last), .low_full_i(low_full),
        .hrq_o(hrq_o), .dack_o(dack_o), .drive_o(drive),
        .strobe_o(strobe), .step_o(step)
    );

    // Strobe pairing by direction and terminal-count indication.
    always_comb begin
        is_cascade = (mode == XM_CASCADE);
        masked_o   = masked;
        addr_oe_o  = drive;
        cmd_oe_o   = drive;
        memr_n_o   = !(strobe && to_dev);
        iow_n_o    = !(strobe && to_dev);
        ior_n_o    = !(strobe && !to_dev);
        memw_n_o   = !(strobe && !to_dev);
        tc_o       = drive && last;
    end

endmodule

// File: rtl/dma_chan_chk.sv
// Assertion checker for dma_chan, bound to every instance.
// Assumes the grant stays high while hold request is high.
module dma_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic hlda_i,
    input logic hrq_o,
    input logic dack_o,
    input logic addr_oe_o,
    input logic cmd_oe_o,
    input logic memr_n_o,
    input logic memw_n_o,
    input logic ior_n_o,
    input logic iow_n_o,
    input logic tc_o,
    input logic tc_flag_o,
    input logic masked_o,
    input logic is_cascade
);

    // R4
    dack_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack_o |-> hlda_i);

    // R4
    drive_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe_o || cmd_oe_o) |-> dack_o);

    // R5
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!memr_n_o || !memw_n_o || !ior_n_o || !iow_n_o) |->
        ((!memr_n_o && !iow_n_o && memw_n_o && ior_n_o) ||
         (!ior_n_o && !memw_n_o && memr_n_o && iow_n_o)));

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        masked_o |-> (!hrq_o && !dack_o));

    // R8
    tc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tc_o) |-> (tc_flag_o && masked_o));

    // R12
    cascade_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cascade |-> (!addr_oe_o && !cmd_oe_o));

endmodule

bind dma_chan dma_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hlda_i(hlda_i), .hrq_o(hrq_o),
    .dack_o(dack_o), .addr_oe_o(addr_oe_o), .cmd_oe_o(cmd_oe_o),
    .memr_n_o(memr_n_o), .memw_n_o(memw_n_o), .ior_n_o(ior_n_o),
    .iow_n_o(iow_n_o), .tc_o(tc_o), .tc_flag_o(tc_flag_o),
    .masked_o(masked_o), .is_cascade(is_cascade)
);

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        dreq = 1'b0;
    logic        hlda = 1'b0;
    logic        hrq_o, dack_o, addr_oe_o, cmd_oe_o;
    logic        memr_n_o, memw_n_o, ior_n_o, iow_n_o;
    logic        tc_o, tc_flag_o, masked_o;
    logic [15:0] addr_o;
    bit          grant_en = 1'b1;
    int          total = 0;
    int          bad = 0;

    dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .dreq_i(dreq), .hlda_i(hlda),
        .hrq_o(hrq_o), .dack_o(dack_o), .addr_o(addr_o),
        .addr_oe_o(addr_oe_o), .cmd_oe_o(cmd_oe_o),
        .memr_n_o(memr_n_o), .memw_n_o(memw_n_o),
        .ior_n_o(ior_n_o), .iow_n_o(iow_n_o),
        .tc_o(tc_o), .tc_flag_o(tc_flag_o), .masked_o(masked_o)
    );

    always #5 clk = ~clk;

    // Processor model: grant is hold request seen one half-cycle earlier.
    initial forever begin
        @(negedge clk);
        hlda = grant_en && hrq_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prog(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expected acknowledge clocks for a job of n bytes from address a.
    function automatic int exp_cyc(input logic [15:0] a, input int n,
                                   input bit comp, input bit single);
        int r;
        if (!comp) return 4 * n;
        if (single) return 3 * n;
        r = 3;
        for (int i = 1; i < n; i++) begin
            logic [15:0] p;
            p = a + 16'(i - 1);
            r += (p[7:0] == 8'hFF) ? 3 : 2;
        end
        return r;
    endfunction

    // Raise the request and observe transfers until terminal count
    // (or, with drop_first, until the bus is released after one byte).
    task automatic watch(input logic [15:0] a0, input int last_idx,
                         input bit drop_first, input bit dir,
                         output int nx, output int ndack,
                         output int nrise, output int errs);
        bit ph, ps, sn;
        nx = 0; ndack = 0; nrise = 0; errs = 0; ph = 1'b0; ps = 1'b0;
        @(negedge clk);
        dreq = 1'b1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #1;
            if (dack_o) ndack++;
            if (hrq_o && !ph) nrise++;
            sn = dir ? !memr_n_o : !memw_n_o;
            if (sn && !ps) begin
                if (addr_o !== a0 + 16'(nx)) errs++;
                if (dir ? !(!iow_n_o && memw_n_o && ior_n_o)
                        : !(!ior_n_o && memr_n_o && iow_n_o)) errs++;
                if (!addr_oe_o || !cmd_oe_o || !dack_o) errs++;
                if (tc_o !== (nx == last_idx)) errs++;
                nx++;
                if (drop_first) dreq = 1'b0;
            end
            ph = hrq_o; ps = sn;
            if (tc_flag_o) break;
            if (drop_first && nx > 0 && !hrq_o) break;
        end
        dreq = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nx, nd, nr, er, n, seen;
        logic [15:0] a;
        logic [15:0] alist [4];
        int nlist [3];
        alist = '{16'h00FC, 16'h12FE, 16'hFFFD, 16'h0040};
        nlist = '{1, 2, 5};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 masked", int'(masked_o), 1);
        chk("R1 tc flag", int'(tc_flag_o), 0);
        chk("R1 hrq/dack", int'({hrq_o, dack_o}), 0);
        chk("R1 enables", int'({addr_oe_o, cmd_oe_o}), 0);

        // R3 request ignored while masked
        prog(2'd2, 16'h0002);
        prog(2'd0, 16'h1000);
        prog(2'd1, 16'h0003);
        dreq = 1'b1;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (hrq_o || dack_o) seen++;
        end
        dreq = 1'b0;
        chk("R3 masked request", seen, 0);

        // R4 no acknowledge or drive before the grant
        prog(2'd3, 16'h0000);
        grant_en = 1'b0;
        @(negedge clk); dreq = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        chk("R4 hrq raised", int'(hrq_o), 1);
        chk("R4 no ack/drive without grant", int'({dack_o, addr_oe_o, cmd_oe_o}), 0);
        grant_en = 1'b1;
        for (int i = 0; i < 200 && !tc_flag_o; i++) @(negedge clk);
        dreq = 1'b0;
        chk("R4 job completes after grant", int'(tc_flag_o), 1);

        // Sweep: timing x direction x mode x address x length (R5..R10)
        for (int ci = 0; ci < 2; ci++)
            for (int di = 0; di < 2; di++)
                for (int m = 0; m < 3; m++)
                    for (int ai = 0; ai < 4; ai++)
                        for (int ni = 0; ni < 3; ni++) begin
                            n = nlist[ni];
                            a = alist[ai];
                            prog(2'd2, {12'd0, 1'(ci), 1'(di), 2'(m)});
                            prog(2'd0, a);
                            prog(2'd1, 16'(n - 1));
                            prog(2'd3, 16'h0000);
                            watch(a, n - 1, m == 2, 1'(di), nx, nd, nr, er);
                            chk("R8 transfer count", nx, n);
                            chk(ci != 0 ? "R7 compressed clocks" : "R6 normal clocks",
                                nd, exp_cyc(a, n, 1'(ci), m == 1));
                            chk(m == 1 ? "R9 single releases" :
                                (m == 2 ? "R10 block one grant" : "R11 demand one grant"),
                                nr, (m == 1) ? n : 1);
                            chk("R5 address/strobe/tc", er, 0);
                            chk("R8 flag and mask", int'({tc_flag_o, masked_o}), 3);
                        end

        // R11 demand burst ends on low request and resumes later
        a = 16'h20FF;
        prog(2'd2, 16'h0008);
        prog(2'd0, a);
        prog(2'd1, 16'd3);
        prog(2'd3, 16'h0000);
        watch(a, -1, 1'b1, 1'b0, nx, nd, nr, er);
        chk("R11 one byte then release", nx, 1);
        chk("R11 not finished", int'({tc_flag_o, masked_o, hrq_o}), 0);
        chk("R11 first burst ok", er, 0);
        watch(a + 16'd1, 2, 1'b0, 1'b0, nx, nd, nr, er);
        chk("R11 resumed bytes", nx, 3);
        chk("R11 resumed address/tc", er, 0);
        chk("R7 resumed clocks", nd, exp_cyc(a + 16'd1, 3, 1'b1, 1'b0));

        // R2 unmask reruns from base and clears the flag
        a = 16'h3456;
        prog(2'd2, 16'h0006);
        prog(2'd0, a);
        prog(2'd1, 16'd2);
        prog(2'd3, 16'h0000);
        watch(a, 2, 1'b0, 1'b1, nx, nd, nr, er);
        chk("R2 first run", nx, 3);
        prog(2'd3, 16'h0000);
        #1;
        chk("R2 flag cleared on unmask", int'({tc_flag_o, masked_o}), 0);
        watch(a, 2, 1'b0, 1'b1, nx, nd, nr, er);
        chk("R2 rerun bytes", nx, 3);
        chk("R2 rerun from base", er, 0);

        // R12 cascade relays request and grant, drives nothing
        prog(2'd2, 16'h0003);
        prog(2'd3, 16'h0000);
        @(negedge clk); dreq = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 hrq follows request", int'(hrq_o), 1);
        chk("R12 ack follows grant", int'(dack_o), 1);
        chk("R12 no drive", int'({addr_oe_o, cmd_oe_o}), 0);
        grant_en = 1'b0;
        @(negedge clk); #1;
        chk("R12 ack drops with grant", int'({hrq_o, dack_o}), 2);
        grant_en = 1'b1;
        dreq = 1'b0;
        @(negedge clk); #1;
        chk("R12 release", int'({hrq_o, dack_o}), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule